// File: doc/BRIEF.md
# Line Rate Monitor and HD Detector

This block watches a sliced composite sync bit, one that is already synchronous to the system clock, and times the distance in clock cycles between successive sync-start edges. Sync start is the 1-to-0 transition of the bit, because the sync tip is the low level. The block reports that distance as the line period. It classes each measured line as high or standard definition and raises an active-low high-definition flag. That flag changes only after several measurements in a row point the same way, so the vertical interval cannot make it flicker.

The equalizing and serration pulses of the vertical interval arrive at half the line spacing. Edges that come too soon after the last accepted edge are therefore dropped, and timing carries on from the accepted edge. If no accepted edge arrives for a long time, sync is declared lost. The sync-valid output then drops and the composite sync output is forced low. The stored period and the flag keep their last values. All time limits are parameters counted in clock cycles. The defaults assume a 250 MHz clock: 50 µs gives 12500 cycles and 128 µs gives 32000 cycles.

Top module: `line_rate_monitor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, syncValid is 0, hdN is 1, linePeriod is 0 and csyncOut is 0.
- R2: A falling edge is a cycle where syncIn is 0 and it was 1 on the previous cycle. When an edge is accepted, linePeriod shows the number of clock cycles since the previous accepted edge, starting on the next cycle. linePeriod changes at no other time.
- R3: While syncValid is 1, an edge is ignored when its distance D from the last accepted edge satisfies 5·D < 3·linePeriod (under 60 %). Nothing changes on an ignored edge, and the next distance is still counted from the last accepted edge.
- R4: An accepted distance below HD_LIMIT cycles is classed as high definition. A distance equal to or above HD_LIMIT is classed as standard definition.
- R5: hdN changes only after AGREE_COUNT (default 4) accepted measurements in a row disagree with its present value. hdN is 1 for standard and 0 for high definition. Any accepted measurement that agrees with hdN restarts the run.
- R6: When LOSS_LIMIT cycles pass after the last accepted edge, or after the first edge following a loss, with no accepted edge, syncValid goes to 0. linePeriod and hdN keep their values. A distance of LOSS_LIMIT−1 still counts as a valid line.
- R7: After reset or a loss, the first falling edge only starts timing. The second edge gives a measurement that is accepted whatever the stored period is, and syncValid becomes 1 on the next cycle.
- R8: csyncOut on each cycle equals syncIn AND syncValid as they were on the previous cycle. It is therefore held low whenever sync is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| syncIn | input | 1 | Sliced composite sync, low during sync tips |
| linePeriod | output | CNT_W | Last accepted line period in clock cycles |
| hdN | output | 1 | Low when the input is high definition |
| syncValid | output | 1 | High while sync is locked |
| csyncOut | output | 1 | Composite sync, gated low while sync is not valid |

## Verification
The hardest situation to reach is the rejection of half-line edges, and above all the exact 60 % boundary. Rejection happens only while sync is locked, and it depends on the distance from the last *accepted* edge, not from the last edge. The stimulus builds locked standard lines, then runs a train of half-spaced pulses, then places edges one cycle on either side of the ratio limit. The result shows only on the period port, which must hold steady. Moving from a standard to a high-definition rate also needs a sync loss first, so the bench inserts silent gaps before the change of rate.

// File: rtl/lrm_pkg.sv
package lrm_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // restart interval count at this edge
    logic measure;   // capture the interval as the new period
    logic lost;      // sync loss declared this cycle
  } lrmCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic fall;      // sync start edge this cycle
    logic halfLine;  // interval under 60 % of stored period
    logic hdClass;   // interval below the HD limit
    logic timeout;   // interval reached the loss limit
  } lrmStat_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOCKED = 2'd2
  } lrmState_t;

endpackage

// File: rtl/lrm_datapath.sv
module lrm_datapath
  import lrm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int HD_LIMIT   = 12500,
  parameter int LOSS_LIMIT = 32000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             syncIn,
  input  logic             syncValid,
  input  lrmCtrl_t         ctrl,
  output lrmStat_t         stat,
  output logic [CNT_W-1:0] linePeriod,
  output logic             csyncOut
);

  localparam int CMP_W = CNT_W + 3;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] HD_LIM   = CNT_W'(HD_LIMIT);
  localparam logic [CNT_W-1:0] LOSS_LIM = CNT_W'(LOSS_LIMIT);

  logic             syncPrev;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodQ;
  logic             csyncQ;
  logic [CMP_W-1:0] cntX5;
  logic [CMP_W-1:0] perX3;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncPrev <= 1'b1;
      cnt      <= '0;
      periodQ  <= '0;
      csyncQ   <= 1'b0;
    end else begin
      syncPrev <= syncIn;
      csyncQ   <= syncIn & syncValid;
      if (ctrl.restart)
        cnt <= CNT_W'(1);
      else if (cnt != CNT_MAX)
        cnt <= cnt + CNT_W'(1);
      if (ctrl.measure)
        periodQ <= cnt;
    end
  end

  // ratio test by shift-add: 5*cnt against 3*period
  assign cntX5 = (CMP_W'(cnt) << 2) + CMP_W'(cnt);
  assign perX3 = (CMP_W'(periodQ) << 1) + CMP_W'(periodQ);

  always_comb begin
    stat          = '0;
    stat.fall     = syncPrev & ~syncIn;
    stat.halfLine = cntX5 < perX3;
    stat.hdClass  = cnt < HD_LIM;
    stat.timeout  = cnt >= LOSS_LIM;
  end

  assign linePeriod = periodQ;
  assign csyncOut   = csyncQ;

  assert_period_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl.measure |=> $stable(linePeriod));

  assert_measure_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl.measure |-> stat.fall);

  assert_half_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (syncValid && stat.fall && stat.halfLine) |=> $stable(linePeriod));

  assert_csync_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !syncValid |=> !csyncOut);

endmodule

// File: rtl/lrm_control.sv
module lrm_control
  import lrm_pkg::*;
#(
  parameter int AGREE_COUNT = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  lrmStat_t stat,
  output lrmCtrl_t ctrl,
  output logic     syncValid,
  output logic     hdN
);

  localparam int AGR_W = $clog2(AGREE_COUNT + 1);
  localparam logic [AGR_W-1:0] AGR_LAST = AGR_W'(AGREE_COUNT - 1);
  localparam logic [AGR_W-1:0] AGR_TOP  = AGR_W'(AGREE_COUNT);

  lrmState_t      st, stNext;
  logic [AGR_W-1:0] agree;
  logic           hdQ;
  logic           disagree;

  always_comb begin
    ctrl   = '0;
    stNext = st;
    case (st)
      ST_IDLE: begin
        if (stat.fall) begin
          ctrl.restart = 1'b1;
          stNext       = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (stat.timeout) begin
          ctrl.lost = 1'b1;
          stNext    = ST_IDLE;
        end else if (stat.fall) begin
          ctrl.restart = 1'b1;
          ctrl.measure = 1'b1;
          stNext       = ST_LOCKED;
        end
      end
      ST_LOCKED: begin
        if (stat.timeout) begin
          ctrl.lost = 1'b1;
          stNext    = ST_IDLE;
        end else if (stat.fall && !stat.halfLine) begin
          ctrl.restart = 1'b1;
          ctrl.measure = 1'b1;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  // class 1 = HD; hdQ 1 = standard, so equal values mean disagreement
  assign disagree = (stat.hdClass == hdQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      hdQ   <= 1'b1;
      agree <= '0;
    end else begin
      st <= stNext;
      if (ctrl.lost) begin
        agree <= '0;
      end else if (ctrl.measure) begin
        if (disagree) begin
          if (agree == AGR_LAST) begin
            hdQ   <= ~hdQ;
            agree <= '0;
          end else begin
            agree <= agree + AGR_W'(1);
          end
        end else begin
          agree <= '0;
        end
      end
    end
  end

  assign syncValid = (st == ST_LOCKED);
  assign hdN       = hdQ;

  assert_hd_only_on_measure_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.measure |=> $stable(hdN));

  assert_agree_bound_R5: assert property (@(posedge clk) disable iff (rst)
    agree < AGR_TOP);

  assert_loss_drops_valid_R6: assert property (@(posedge clk) disable iff (rst)
    stat.timeout |=> !syncValid);

  assert_lock_needs_edge_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(syncValid) |-> $past(stat.fall));

endmodule

// File: rtl/line_rate_monitor.sv
module line_rate_monitor
  import lrm_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int HD_LIMIT    = 12500,
  parameter int LOSS_LIMIT  = 32000,
  parameter int AGREE_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             syncIn,
  output logic [CNT_W-1:0] linePeriod,
  output logic             hdN,
  output logic             syncValid,
  output logic             csyncOut
);

  lrmCtrl_t ctrlBus;
  lrmStat_t statBus;

  lrm_datapath #(
    .CNT_W      (CNT_W),
    .HD_LIMIT   (HD_LIMIT),
    .LOSS_LIMIT (LOSS_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .syncIn     (syncIn),
    .syncValid  (syncValid),
    .ctrl       (ctrlBus),
    .stat       (statBus),
    .linePeriod (linePeriod),
    .csyncOut   (csyncOut)
  );

  lrm_control #(
    .AGREE_COUNT (AGREE_COUNT)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .stat      (statBus),
    .ctrl      (ctrlBus),
    .syncValid (syncValid),
    .hdN       (hdN)
  );

endmodule

// File: tb/line_rate_monitor_tb.sv
module line_rate_monitor_tb;

  localparam int CNT_W = 12;
  localparam int HDL   = 500;
  localparam int LOSS  = 1280;
  localparam int AGR   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic syncIn = 1'b1;
  logic [CNT_W-1:0] linePeriod;
  logic hdN, syncValid, csyncOut;

  always #2 clk = ~clk;  // 250 MHz

  line_rate_monitor #(
    .CNT_W(CNT_W), .HD_LIMIT(HDL), .LOSS_LIMIT(LOSS), .AGREE_COUNT(AGR)
  ) u_dut (
    .clk(clk), .rst(rst), .syncIn(syncIn),
    .linePeriod(linePeriod), .hdN(hdN), .syncValid(syncValid), .csyncOut(csyncOut)
  );

  typedef struct { string req; int per; bit hd; bit val; } exp_t;
  exp_t expQ[$];
  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // reference model state, built from the requirements
  int mAcc = 0, mPer = 0, mAgree = 0;
  bit mHdN = 1'b1, mValid = 1'b0, mArmed = 1'b0;

  task automatic pushExp(string r);
    exp_t e;
    e.req = r; e.per = mPer; e.hd = mHdN; e.val = mValid;
    expQ.push_back(e);
  endtask

  task automatic modelLoss();
    if (mArmed && mAcc >= LOSS) begin
      mArmed = 1'b0; mValid = 1'b0; mAgree = 0;
    end
  endtask

  task automatic modelFall();
    bit cls;
    modelLoss();
    if (!mArmed) begin
      mArmed = 1'b1; mAcc = 0;
    end else if (mValid && (mAcc * 5 < mPer * 3)) begin
      // half line: ignored, timing continues
    end else begin
      cls = (mAcc < HDL);
      if (cls == mHdN) begin
        if (mAgree == AGR - 1) begin mHdN = ~mHdN; mAgree = 0; end
        else mAgree++;
      end else mAgree = 0;
      mPer = mAcc; mValid = 1'b1; mAcc = 0;
    end
  endtask

  // one line: sync tip of w cycles, total length d cycles
  task automatic line(int d, int w, string r);
    syncIn = 1'b0;
    modelFall();
    repeat (w) @(negedge clk);
    syncIn = 1'b1;
    pushExp(r);
    repeat (d - w) @(negedge clk);
    mAcc += d;
  endtask

  task automatic gap(int n, string r);
    syncIn = 1'b1;
    repeat (n) @(negedge clk);
    mAcc += n;
    modelLoss();
    pushExp(r);
  endtask

  // monitor: scoreboard pops and per-cycle gate check
  initial begin
    bit prevValid = 1'b0;
    exp_t e;
    forever begin
      @(posedge clk); #1;
      nCmp++;
      if (csyncOut !== (prevValid & syncIn)) begin
        nBad++;
        $display("FAIL R8 csyncOut actual %0b expected %0b at %0t", csyncOut, prevValid & syncIn, $time);
      end
      prevValid = syncValid;
      while (expQ.size() > 0) begin
        e = expQ.pop_front();
        nCmp++;
        if (int'(linePeriod) != e.per) begin
          nBad++;
          $display("FAIL %s linePeriod actual %0d expected %0d at %0t", e.req, linePeriod, e.per, $time);
        end
        nCmp++;
        if (hdN !== e.hd) begin
          nBad++;
          $display("FAIL %s hdN actual %0b expected %0b at %0t", e.req, hdN, e.hd, $time);
        end
        nCmp++;
        if (syncValid !== e.val) begin
          nBad++;
          $display("FAIL %s syncValid actual %0b expected %0b at %0t", e.req, syncValid, e.val, $time);
        end
      end
    end
  end

  // driver
  initial begin
    repeat (4) @(negedge clk);
    pushExp("R1");                     // reset state
    rst = 1'b0;
    @(negedge clk);
    pushExp("R1");                     // first cycle out of reset
    @(negedge clk);
    line(636, 47, "R7");               // arms only
    line(636, 47, "R7");               // first measurement locks
    for (int i = 0; i < 4; i++) line(636, 47, "R2");
    for (int i = 0; i < 6; i++) line(318, 23, "R3"); // half-line train
    line(381, 23, "R3");               // next edge at 381: 5*381 < 3*636, dropped
    line(255, 23, "R3");
    line(382, 23, "R3");               // next edge at 382: just accepted
    line(636, 47, "R5");               // HD-class measurement, run of one
    line(636, 47, "R5");               // agreeing one resets the run
    line(1279, 47, "R6");
    line(636, 47, "R6");               // LOSS-1 distance still locked
    gap(1400, "R6");                   // loss: period and flag hold
    for (int i = 0; i < 8; i++) line(300, 20, "R5"); // relock at HD rate
    for (int i = 0; i < 4; i++) line(499, 20, "R4"); // just below limit: HD
    line(500, 20, "R5");
    line(300, 20, "R5");               // one SD-class measurement
    for (int i = 0; i < 3; i++) line(300, 20, "R5");
    for (int i = 0; i < 4; i++) line(500, 20, "R4"); // at the limit: SD
    line(300, 20, "R4");               // fourth SD measurement flips hdN
    gap(2000, "R6");
    line(300, 20, "R8");               // armed, output still gated
    gap(10, "R8");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        nBad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule